// File: doc/BRIEF.md
# Ping-Pong Bulk IN Endpoint Buffer

This block holds the outgoing packets of one bulk IN endpoint in a small byte-wide packet memory, split into two packet slots. Each slot has a base address and a byte count. A producer writes bytes into the free slot and then commits a length. The serializer side raises a one-cycle token strobe for each IN token. The block answers with a data response that carries the slot and its length, or with a NAK when nothing is ready. The serializer then fetches the payload bytes by offset and finally reports whether the host acknowledged the packet.

In ping-pong mode the two slots alternate. The endpoint select bit (`ep_sel`) names the slot the host drains next, and it inverts only after an acknowledged transaction. The producer-facing `fill_sel` names the slot that the next write or commit targets, so the producer can fill one slot while the other is being sent. A failed transaction leaves everything in place, and the same slot is offered again. In single mode only slot 0 is used. A commit is refused, with an error pulse, when it targets a full slot or asks for more than the maximum packet size. A zero-length commit is legal.

Top module: `dbi_bulk_in_ep`

## Requirements
- R1: After reset both slots are empty with count zero, `ep_sel` and `fill_sel` are 0, and `resp_data`, `resp_nak` and `prod_err` are 0.
- R2: A token that arrives with no transaction in progress, while the slot at `ep_sel` is empty, gives a one-cycle `resp_nak` in the next cycle and no `resp_data`.
- R3: A token that arrives with no transaction in progress, while the slot at `ep_sel` is full, gives a one-cycle `resp_data` in the next cycle, with `resp_buf` naming the slot and `resp_len` equal to its committed length. `rd_en` with offset k returns, in the following cycle, the byte the producer wrote at offset k of that slot.
- R4: `txn_done` with `txn_ack`=1 during a transaction empties the drained slot. In ping-pong mode (`cfg_dbl`=1) it also inverts `ep_sel`.
- R5: `txn_done` with `txn_ack`=0 leaves the slot full and `ep_sel` unchanged, and the next token offers the same slot with the same length.
- R6: In ping-pong mode `fill_sel` equals `ep_sel` when the slot at `ep_sel` is empty, and the other slot otherwise. A successful commit marks the `fill_sel` slot full with `prod_len`.
- R7: A commit while the `fill_sel` slot is full is refused. `prod_err` pulses for one cycle in the next cycle, and no slot or length changes.
- R8: A commit with `prod_len` greater than MAX_PKT (default 64) is refused with a `prod_err` pulse, and it leaves the slot empty.
- R9: A commit of length 0 makes the slot full, and the next token gets a data response with `resp_len` 0.
- R10: In single mode (`cfg_dbl`=0) only slot 0 is used: `fill_sel` and `ep_sel` stay 0, including after an acknowledged transaction.
- R11: Byte writes to a full slot are ignored, so the bytes of a committed packet do not change.
- R12: A token that arrives while a transaction is in progress gets no response.
- R13: An acknowledge and a commit in the same cycle both take effect. The commit is judged on the slot state before that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dbl | input | 1 | 1 = ping-pong mode, 0 = single slot |
| cfg_base0 | input | ADDR_W | Base address of slot 0 in packet memory |
| cfg_base1 | input | ADDR_W | Base address of slot 1 in packet memory |
| prod_we | input | 1 | Producer byte write strobe |
| prod_offs | input | OFFS_W | Byte offset within the `fill_sel` slot |
| prod_data | input | 8 | Byte to write |
| prod_commit | input | 1 | Commit the `fill_sel` slot |
| prod_len | input | LEN_W | Packet length for the commit |
| fill_sel | output | 1 | Slot the producer targets next |
| prod_err | output | 1 | One-cycle pulse: commit refused |
| ep_sel | output | 1 | Endpoint select bit: slot drained next |
| in_token | input | 1 | IN token strobe from the serializer |
| resp_data | output | 1 | One-cycle pulse: data response |
| resp_nak | output | 1 | One-cycle pulse: NAK response |
| resp_buf | output | 1 | Slot of the current transaction |
| resp_len | output | LEN_W | Byte count of the current transaction |
| rd_en | input | 1 | Payload byte fetch strobe |
| rd_offs | input | OFFS_W | Payload byte offset |
| rd_data | output | 8 | Fetched byte, valid the cycle after `rd_en` |
| txn_done | input | 1 | Transaction end strobe |
| txn_ack | input | 1 | Host acknowledged (valid with `txn_done`) |

## Verification
The acknowledge that frees the drained slot and a producer commit into the other slot can land in the same cycle. The bench provokes this by raising `txn_done`/`txn_ack` together with `prod_commit` of a zero-length packet while slot 1 is being sent. It judges the outcome by checking three things: that no error pulse appears, that `ep_sel` and `fill_sel` both move to their new values, and that the next token is answered from slot 0 with length zero. A second overlap is a token that arrives while a transaction is still open. The bench checks that no response of either kind appears in that case.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
  localparam int NBUF = 2;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } txn_st_e;
endpackage

// File: rtl/dbi_pkt_mem.sv
module dbi_pkt_mem #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];
  logic [7:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (re) rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/dbi_buf_state.sv
module dbi_buf_state
  import dbi_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        set_en,
  input  logic                        set_idx,
  input  logic [LEN_W-1:0]            set_len,
  input  logic                        clr_en,
  input  logic                        clr_idx,
  output logic [NBUF-1:0]             full_o,
  output logic [NBUF-1:0][LEN_W-1:0]  cnt_o
);
  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    logic             full_d, full_q;
    logic [LEN_W-1:0] cnt_d, cnt_q;

    always_comb begin
      full_d = full_q;
      cnt_d  = cnt_q;
      if (set_en && (set_idx == 1'(b))) begin
        full_d = 1'b1;
        cnt_d  = set_len;
      end
      if (clr_en && (clr_idx == 1'(b))) begin
        full_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        full_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        full_q <= full_d;
        cnt_q  <= cnt_d;
      end
    end

    assign full_o[b] = full_q;
    assign cnt_o[b]  = cnt_q;
  end
endmodule

// File: rtl/dbi_txn_ctl.sv
module dbi_txn_ctl
  import dbi_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbl,
  input  logic             in_token,
  input  logic             txn_done,
  input  logic             txn_ack,
  input  logic             drain_full,
  input  logic [LEN_W-1:0] drain_cnt,
  output logic             eff_sel,
  output logic             ack_evt,
  output logic             resp_data,
  output logic             resp_nak,
  output logic             resp_buf,
  output logic [LEN_W-1:0] resp_len
);
  txn_st_e          st_d, st_q;
  logic             sel_d, sel_q;
  logic             rdat_d, rdat_q;
  logic             rnak_d, rnak_q;
  logic             buf_d, buf_q;
  logic [LEN_W-1:0] len_d, len_q;

  assign eff_sel = sel_q & dbl;

  always_comb begin
    st_d    = st_q;
    sel_d   = sel_q;
    rdat_d  = 1'b0;
    rnak_d  = 1'b0;
    buf_d   = buf_q;
    len_d   = len_q;
    ack_evt = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (in_token) begin
          if (drain_full) begin
            st_d   = ST_XFER;
            rdat_d = 1'b1;
            buf_d  = eff_sel;
            len_d  = drain_cnt;
          end else begin
            rnak_d = 1'b1;
          end
        end
      end
      ST_XFER: begin
        if (txn_done) begin
          st_d = ST_IDLE;
          if (txn_ack) begin
            ack_evt = 1'b1;
            if (dbl) sel_d = ~eff_sel;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sel_q  <= 1'b0;
      rdat_q <= 1'b0;
      rnak_q <= 1'b0;
      buf_q  <= 1'b0;
      len_q  <= '0;
    end else begin
      st_q   <= st_d;
      sel_q  <= sel_d;
      rdat_q <= rdat_d;
      rnak_q <= rnak_d;
      buf_q  <= buf_d;
      len_q  <= len_d;
    end
  end

  assign resp_data = rdat_q;
  assign resp_nak  = rnak_q;
  assign resp_buf  = buf_q;
  assign resp_len  = len_q;
endmodule

// File: rtl/dbi_bulk_in_ep.sv
module dbi_bulk_in_ep
  import dbi_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int MAX_PKT = 64,
  localparam int OFFS_W = $clog2(MAX_PKT),
  localparam int LEN_W  = $clog2(MAX_PKT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_dbl,
  input  logic [ADDR_W-1:0] cfg_base0,
  input  logic [ADDR_W-1:0] cfg_base1,
  input  logic              prod_we,
  input  logic [OFFS_W-1:0] prod_offs,
  input  logic [7:0]        prod_data,
  input  logic              prod_commit,
  input  logic [LEN_W-1:0]  prod_len,
  output logic              fill_sel,
  output logic              prod_err,
  output logic              ep_sel,
  input  logic              in_token,
  output logic              resp_data,
  output logic              resp_nak,
  output logic              resp_buf,
  output logic [LEN_W-1:0]  resp_len,
  input  logic              rd_en,
  input  logic [OFFS_W-1:0] rd_offs,
  output logic [7:0]        rd_data,
  input  logic              txn_done,
  input  logic              txn_ack
);
  // slot descriptor: base address and byte count per slot, slot 0 first
  logic [ADDR_W-1:0]            base [NBUF];
  logic [NBUF-1:0]              full;
  logic [NBUF-1:0][LEN_W-1:0]   cnt;

  logic eff_sel, ack_evt;
  logic fill_free, len_ok, commit_ok, wr_ok;
  logic err_d, err_q;

  assign base[0] = cfg_base0;
  assign base[1] = cfg_base1;

  assign fill_sel  = cfg_dbl ? (eff_sel ^ full[eff_sel]) : 1'b0;
  assign fill_free = ~full[fill_sel];
  assign len_ok    = (prod_len <= LEN_W'(MAX_PKT));
  assign commit_ok = prod_commit & fill_free & len_ok;
  assign wr_ok     = prod_we & fill_free;
  assign err_d     = prod_commit & ~commit_ok;

  dbi_buf_state #(.LEN_W(LEN_W)) i_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (commit_ok),
    .set_idx (fill_sel),
    .set_len (prod_len),
    .clr_en  (ack_evt),
    .clr_idx (resp_buf),
    .full_o  (full),
    .cnt_o   (cnt)
  );

  dbi_txn_ctl #(.LEN_W(LEN_W)) i_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .dbl        (cfg_dbl),
    .in_token   (in_token),
    .txn_done   (txn_done),
    .txn_ack    (txn_ack),
    .drain_full (full[eff_sel]),
    .drain_cnt  (cnt[eff_sel]),
    .eff_sel    (eff_sel),
    .ack_evt    (ack_evt),
    .resp_data  (resp_data),
    .resp_nak   (resp_nak),
    .resp_buf   (resp_buf),
    .resp_len   (resp_len)
  );

  dbi_pkt_mem #(.ADDR_W(ADDR_W)) i_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_ok),
    .waddr (base[fill_sel] + ADDR_W'(prod_offs)),
    .wdata (prod_data),
    .re    (rd_en),
    .raddr (base[resp_buf] + ADDR_W'(rd_offs)),
    .rdata (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign prod_err = err_q;
  assign ep_sel   = eff_sel;
endmodule

// File: rtl/dbi_bulk_in_ep_chk.sv
module dbi_bulk_in_ep_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_dbl,
  input logic prod_commit,
  input logic prod_err,
  input logic ep_sel,
  input logic in_token,
  input logic resp_data,
  input logic resp_nak,
  input logic txn_done,
  input logic txn_ack
);
  // R2
  resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_data && resp_nak));

  // R2
  nak_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_nak |-> $past(in_token));

  // R3
  data_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_data |-> $past(in_token));

  // R7
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prod_err |-> $past(prod_commit));

  // R4
  sel_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_sel != $past(ep_sel)) |-> $past(txn_done && txn_ack));

  // R10
  single_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_dbl && !$past(cfg_dbl)) |-> !ep_sel);
endmodule

bind dbi_bulk_in_ep dbi_bulk_in_ep_chk i_chk (.*);

// File: tb/test_dbi_bulk_in_ep.sv
module test_dbi_bulk_in_ep;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int MAX_PKT = 64;
  localparam int OFFS_W = $clog2(MAX_PKT);
  localparam int LEN_W  = $clog2(MAX_PKT + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_dbl = 1'b1;
  logic [ADDR_W-1:0] cfg_base0 = 8'h00;
  logic [ADDR_W-1:0] cfg_base1 = 8'h80;
  logic prod_we = 1'b0;
  logic [OFFS_W-1:0] prod_offs = '0;
  logic [7:0] prod_data = '0;
  logic prod_commit = 1'b0;
  logic [LEN_W-1:0] prod_len = '0;
  logic fill_sel, prod_err, ep_sel;
  logic in_token = 1'b0;
  logic resp_data, resp_nak, resp_buf;
  logic [LEN_W-1:0] resp_len;
  logic rd_en = 1'b0;
  logic [OFFS_W-1:0] rd_offs = '0;
  logic [7:0] rd_data;
  logic txn_done = 1'b0;
  logic txn_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbi_bulk_in_ep #(.ADDR_W(ADDR_W), .MAX_PKT(MAX_PKT)) i_dbi_bulk_in_ep (
    .clk(clk), .rst_n(rst_n), .cfg_dbl(cfg_dbl),
    .cfg_base0(cfg_base0), .cfg_base1(cfg_base1),
    .prod_we(prod_we), .prod_offs(prod_offs), .prod_data(prod_data),
    .prod_commit(prod_commit), .prod_len(prod_len),
    .fill_sel(fill_sel), .prod_err(prod_err), .ep_sel(ep_sel),
    .in_token(in_token), .resp_data(resp_data), .resp_nak(resp_nak),
    .resp_buf(resp_buf), .resp_len(resp_len),
    .rd_en(rd_en), .rd_offs(rd_offs), .rd_data(rd_data),
    .txn_done(txn_done), .txn_ack(txn_ack)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic dbl);
    rst_n = 1'b0;
    cfg_dbl = dbl;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_byte(input int offs, input int val);
    prod_we = 1'b1; prod_offs = OFFS_W'(offs); prod_data = 8'(val);
    @(negedge clk);
    prod_we = 1'b0;
  endtask

  task automatic commit(input int len, input int exp_err, input string tag);
    prod_commit = 1'b1; prod_len = LEN_W'(len);
    @(negedge clk);
    prod_commit = 1'b0;
    chk({tag, " prod_err"}, prod_err, exp_err);
  endtask

  task automatic load(input int len, input int seed, input string tag);
    for (int i = 0; i < len; i++) wr_byte(i, seed + i);
    commit(len, 0, tag);
  endtask

  task automatic token(input int exp_data, input int exp_buf, input int exp_len,
                       input string tag);
    in_token = 1'b1;
    @(negedge clk);
    in_token = 1'b0;
    chk({tag, " resp_data"}, resp_data, exp_data);
    chk({tag, " resp_nak"}, resp_nak, (exp_data == 0) ? 1 : 0);
    if (exp_data == 1) begin
      chk({tag, " resp_buf"}, resp_buf, exp_buf);
      chk({tag, " resp_len"}, resp_len, exp_len);
    end
  endtask

  task automatic read_pkt(input int len, input int seed, input string tag);
    for (int i = 0; i < len; i++) begin
      rd_en = 1'b1; rd_offs = OFFS_W'(i);
      @(negedge clk);
      rd_en = 1'b0;
      chk({tag, " rd_data"}, rd_data, (seed + i) & 8'hff);
    end
  endtask

  task automatic finish_txn(input logic ack);
    txn_done = 1'b1; txn_ack = ack;
    @(negedge clk);
    txn_done = 1'b0; txn_ack = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R1 ep_sel", ep_sel, 0);
    chk("R1 fill_sel", fill_sel, 0);
    chk("R1 resp_data", resp_data, 0);
    chk("R1 resp_nak", resp_nak, 0);
    chk("R1 prod_err", prod_err, 0);
    token(0, 0, 0, "R1 R2 empty after reset");
  endtask

  task automatic t_pingpong();
    load(5, 8'h10, "R6 slot0");
    chk("R6 fill after slot0", fill_sel, 1);
    load(3, 8'h40, "R6 slot1");
    chk("R6 fill both full", fill_sel, 1);
    commit(4, 1, "R7 both full");
    chk("R7 fill unchanged", fill_sel, 1);
    token(1, 0, 5, "R3 first");
    in_token = 1'b1;
    @(negedge clk);
    in_token = 1'b0;
    chk("R12 no data", resp_data, 0);
    chk("R12 no nak", resp_nak, 0);
    read_pkt(5, 8'h10, "R3 slot0");
    finish_txn(1'b0);
    chk("R5 ep_sel held", ep_sel, 0);
    token(1, 0, 5, "R5 replay");
    read_pkt(5, 8'h10, "R5 slot0 replay");
    finish_txn(1'b1);
    chk("R4 ep_sel flipped", ep_sel, 1);
    chk("R6 fill back to 0", fill_sel, 0);
    token(1, 1, 3, "R3 slot1");
    read_pkt(3, 8'h40, "R3 slot1");
  endtask

  task automatic t_overlap();
    txn_done = 1'b1; txn_ack = 1'b1;
    prod_commit = 1'b1; prod_len = '0;
    @(negedge clk);
    txn_done = 1'b0; txn_ack = 1'b0; prod_commit = 1'b0;
    chk("R13 no err", prod_err, 0);
    chk("R13 ep_sel", ep_sel, 0);
    chk("R13 fill_sel", fill_sel, 1);
    token(1, 0, 0, "R9 zero length");
    finish_txn(1'b1);
    chk("R4 ep_sel after zlp", ep_sel, 1);
    token(0, 0, 0, "R2 drained");
    commit(65, 1, "R8 oversize");
    token(0, 0, 0, "R8 still empty");
  endtask

  task automatic t_single();
    do_reset(1'b0);
    chk("R1 single reset ep_sel", ep_sel, 0);
    load(2, 8'h70, "R10 single");
    chk("R10 fill_sel", fill_sel, 0);
    wr_byte(0, 8'hEE);
    commit(1, 1, "R7 single full");
    token(1, 0, 2, "R10 token");
    read_pkt(2, 8'h70, "R11 untouched");
    finish_txn(1'b1);
    chk("R10 ep_sel stays", ep_sel, 0);
    commit(1, 0, "R10 reuse slot0");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset(1'b1);
    t_reset_state();
    t_pingpong();
    t_overlap();
    t_single();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule